// File: doc/BRIEF.md
# Programmable Flag Offset Register Bank

This block holds the two threshold offsets that a FIFO's partial-flag logic compares against: one for the almost-empty flag and one for the almost-full flag. Each offset is as wide as the FIFO address. The offsets can be programmed in one of two ways. One is a serial path, one bit per clock from a single data pin. The other is a parallel path, one whole word per write from the write data bus. Either way, the stored values can be read back as words on the read data bus.

The programming method is fixed at master reset by the level of the load control input. The same level also picks the reset default for both offsets: 1023 when the input is high and 127 when it is low. A partial reset brings the word pointer and the serial bit position back to their start. It leaves the offsets and the chosen method alone, so a running FIFO can be restarted without reprogramming. Both offsets are driven out continuously to the flag comparators.

Top module: `pfo_offset_bank`

## Requirements
- R1: A master reset (`mrst` high at a clock edge) sets both offsets to 1023 if `cfg_ld` is high and to 127 if it is low, and clears `rd_data` to 0. The new values are visible after that edge.
- R2: The method is latched at master reset: `cfg_ld` high selects parallel loading and `cfg_ld` low selects serial loading. The method changes at no other time, including partial reset.
- R3: In serial mode, each edge with `cfg_ld` and `ser_en` both high stores `ser_din` into the next position of a 2·W-bit chain. The chain runs through almost-empty bits 0 to W-1 (LSB first) and then almost-full bits 0 to W-1. After the last almost-full bit it wraps to almost-empty bit 0. Only the addressed bit changes.
- R4: In parallel mode, each edge with `cfg_ld` and `wr_en` both high writes `wr_data` into the offset chosen by a shared word pointer. The pointer then toggles, so writes alternate almost-empty, almost-full, almost-empty, and so on.
- R5: In either mode, an edge with `cfg_ld` and `rd_en` high and no parallel write in the same cycle copies the offset chosen by the shared pointer into `rd_data` and toggles the pointer.
- R6: `rd_data` keeps its value on every edge without a readback (R5) and without a master reset.
- R7: A partial reset (`prst` high, `mrst` low) returns the word pointer to almost-empty and the serial position to almost-empty bit 0. It leaves both offsets and the method unchanged, and no load or readback takes place in that cycle.
- R8: `ser_en` has no effect in parallel mode. `wr_en` has no effect on the offsets or the pointer in serial mode. Without `cfg_ld`, none of `ser_en`, `wr_en` or `rd_en` has any effect.
- R9: Master reset takes priority over partial reset. A parallel write and a readback requested in the same cycle perform only the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all loading and readback |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| cfg_ld | input | 1 | Load control; also selects default and method during master reset |
| ser_en | input | 1 | Serial bit load enable |
| ser_din | input | 1 | Serial data bit |
| wr_en | input | 1 | Write enable for parallel word load |
| wr_data | input | OFS_W | Parallel offset word |
| rd_en | input | 1 | Read enable for offset readback |
| rd_data | output | OFS_W | Registered readback word |
| ae_offset | output | OFS_W | Almost-empty offset to flag logic |
| af_offset | output | OFS_W | Almost-full offset to flag logic |

## Verification
The assertions check on every cycle that:
- the method latch moves only at master reset;
- the pointer and serial position return home on either reset;
- a serial load changes at most one bit;
- an offset stays still when neither of its strobes fires;
- a partial reset never disturbs the offsets;
- `rd_data` holds between readbacks.

Only the bench scenarios can show that the right offset receives a given word or bit. These cover the full parallel value sweep with alternating readback, serial chains across many patterns, the wrap after the last chain bit, resumption from bit 0 after a partial reset, and the ignored-input cases in each mode.

// File: rtl/pfo_pkg.sv
package pfo_pkg;
   typedef enum logic {
      PROG_SERIAL   = 1'b0,
      PROG_PARALLEL = 1'b1
   } prog_mode_e;

   typedef enum logic {
      SEL_AE = 1'b0,
      SEL_AF = 1'b1
   } ofs_sel_e;
endpackage

// File: rtl/pfo_mode_capture.sv
module pfo_mode_capture
   import pfo_pkg::*;
#(
   parameter int OFS_W   = 10,
   parameter int DFLT_LO = 127,
   parameter int DFLT_HI = 1023
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             cfg_ld,
   output prog_mode_e       mode,
   output logic [OFS_W-1:0] dflt
);
   // default value presented during master reset, chosen by load level
   assign dflt = cfg_ld ? OFS_W'(DFLT_HI) : OFS_W'(DFLT_LO);

   always_ff @(posedge clk) begin
      if (mrst) mode <= cfg_ld ? PROG_PARALLEL : PROG_SERIAL;
   end

   // R2: method only moves on master reset
   p_mode_fixed_r2: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> $stable(mode));
endmodule

// File: rtl/pfo_seq.sv
module pfo_seq
   import pfo_pkg::*;
#(
   parameter int OFS_W = 10,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             prst,
   input  prog_mode_e       mode,
   input  logic             cfg_ld,
   input  logic             ser_en,
   input  logic             wr_en,
   input  logic             rd_en,
   output logic             ser_we,
   output ofs_sel_e         ser_sel,
   output logic [IDX_W-1:0] ser_idx,
   output logic             par_we,
   output logic             rd_go,
   output ofs_sel_e         ptr
);
   localparam int CHAIN = 2 * OFS_W;
   localparam int CNT_W = $clog2(CHAIN);

   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] pos_in_word;
   logic             pos_hi;
   logic             live;

   assign live   = !mrst && !prst;
   assign ser_we = live && cfg_ld && ser_en && (mode == PROG_SERIAL);
   assign par_we = live && cfg_ld && wr_en  && (mode == PROG_PARALLEL);
   assign rd_go  = live && cfg_ld && rd_en  && !par_we;

   assign pos_hi      = (pos >= CNT_W'(OFS_W));
   assign pos_in_word = pos_hi ? (pos - CNT_W'(OFS_W)) : pos;
   assign ser_idx     = pos_in_word[IDX_W-1:0];
   assign ser_sel     = pos_hi ? SEL_AF : SEL_AE;

   always_ff @(posedge clk) begin
      if (mrst || prst) begin
         pos <= '0;
         ptr <= SEL_AE;
      end else begin
         if (ser_we) pos <= (pos == CNT_W'(CHAIN - 1)) ? '0 : pos + 1'b1;
         if (par_we || rd_go) ptr <= (ptr == SEL_AE) ? SEL_AF : SEL_AE;
      end
   end

   // R7: either reset sends pointer and bit position home
   p_home_after_reset_r7: assert property (@(posedge clk)
      (mrst || prst) |=> (ptr == SEL_AE) && (pos == '0));
   // R3: serial position stays inside the chain
   p_pos_bound_r3: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> pos <= CNT_W'(CHAIN - 1));
   // R8: nothing advances the pointer without a word access
   p_ptr_quiet_r8: assert property (@(posedge clk) disable iff (mrst || prst)
      (!par_we && !rd_go && !prst && !mrst) |=> $stable(ptr));
endmodule

// File: rtl/pfo_offset_cell.sv
module pfo_offset_cell #(
   parameter int OFS_W = 10,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic [OFS_W-1:0] dflt,
   input  logic             par_we,
   input  logic [OFS_W-1:0] par_data,
   input  logic             ser_we,
   input  logic [IDX_W-1:0] ser_idx,
   input  logic             ser_bit,
   output logic [OFS_W-1:0] val
);
   always_ff @(posedge clk) begin
      if (mrst)        val <= dflt;
      else if (par_we) val <= par_data;
      else if (ser_we) val[ser_idx] <= ser_bit;
   end

   // R3: a serial strobe touches at most one bit
   p_one_bit_r3: assert property (@(posedge clk) disable iff (mrst)
      (ser_we && !par_we) |=> $countones(val ^ $past(val)) <= 1);
   // R8: value holds when no strobe targets this cell
   p_cell_hold_r8: assert property (@(posedge clk) disable iff (mrst)
      (!par_we && !ser_we) |=> $stable(val));
endmodule

// File: rtl/pfo_offset_bank.sv
module pfo_offset_bank
   import pfo_pkg::*;
#(
   parameter int OFS_W   = 10,
   parameter int DFLT_LO = 127,
   parameter int DFLT_HI = 1023
) (
   input  logic             clk,
   input  logic             mrst,
   input  logic             prst,
   input  logic             cfg_ld,
   input  logic             ser_en,
   input  logic             ser_din,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] wr_data,
   input  logic             rd_en,
   output logic [OFS_W-1:0] rd_data,
   output logic [OFS_W-1:0] ae_offset,
   output logic [OFS_W-1:0] af_offset
);
   localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1;

   if (OFS_W < 2) begin : g_bad_width
      $error("pfo_offset_bank: OFS_W must be at least 2");
   end
   if ($clog2(DFLT_HI + 1) > OFS_W || $clog2(DFLT_LO + 1) > OFS_W) begin : g_bad_default
      $error("pfo_offset_bank: a default offset does not fit in OFS_W");
   end

   prog_mode_e             mode;
   logic [OFS_W-1:0]       dflt;
   logic                   ser_we, par_we, rd_go;
   ofs_sel_e               ser_sel, ptr;
   logic [IDX_W-1:0]       ser_idx;
   logic                   ptr_b, ser_sel_b;
   logic [1:0][OFS_W-1:0]  cells;

   assign ptr_b     = ptr;
   assign ser_sel_b = ser_sel;

   pfo_mode_capture #(.OFS_W(OFS_W), .DFLT_LO(DFLT_LO), .DFLT_HI(DFLT_HI)) u_mode (
      .clk    (clk),
      .mrst   (mrst),
      .cfg_ld (cfg_ld),
      .mode   (mode),
      .dflt   (dflt)
   );

   pfo_seq #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_seq (
      .clk     (clk),
      .mrst    (mrst),
      .prst    (prst),
      .mode    (mode),
      .cfg_ld  (cfg_ld),
      .ser_en  (ser_en),
      .wr_en   (wr_en),
      .rd_en   (rd_en),
      .ser_we  (ser_we),
      .ser_sel (ser_sel),
      .ser_idx (ser_idx),
      .par_we  (par_we),
      .rd_go   (rd_go),
      .ptr     (ptr)
   );

   for (genvar gi = 0; gi < 2; gi++) begin : g_cell
      pfo_offset_cell #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_cell (
         .clk      (clk),
         .mrst     (mrst),
         .dflt     (dflt),
         .par_we   (par_we && (ptr_b == 1'(gi))),
         .par_data (wr_data),
         .ser_we   (ser_we && (ser_sel_b == 1'(gi))),
         .ser_idx  (ser_idx),
         .ser_bit  (ser_din),
         .val      (cells[gi])
      );
   end

   assign ae_offset = cells[0];
   assign af_offset = cells[1];

   always_ff @(posedge clk) begin
      if (mrst)       rd_data <= '0;
      else if (rd_go) rd_data <= cells[ptr_b];
   end

   // R1: defaults follow the load level sampled with master reset
   p_default_r1: assert property (@(posedge clk)
      mrst |=> (ae_offset == ($past(cfg_ld) ? OFS_W'(DFLT_HI) : OFS_W'(DFLT_LO)))
            && (af_offset == ae_offset) && (rd_data == '0));
   // R7: partial reset keeps both offsets
   p_prst_keeps_r7: assert property (@(posedge clk) disable iff (mrst)
      (prst && !mrst) |=> $stable(ae_offset) && $stable(af_offset));
   // R6: readback register holds between readbacks
   p_rd_hold_r6: assert property (@(posedge clk) disable iff (mrst)
      (!rd_go && !mrst) |=> $stable(rd_data));
endmodule

// File: tb/pfo_offset_bank_test.sv
module pfo_offset_bank_test;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         mrst, prst, cfg_ld, ser_en, ser_din, wr_en, rd_en;
   logic [W-1:0] wr_data;
   logic [W-1:0] rd_data, ae_offset, af_offset;

   int  vecs = 0;
   int  errs = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   pfo_offset_bank #(.OFS_W(W)) uut (
      .clk(clk), .mrst(mrst), .prst(prst), .cfg_ld(cfg_ld),
      .ser_en(ser_en), .ser_din(ser_din), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .ae_offset(ae_offset), .af_offset(af_offset)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cyc(bit m, bit p, bit l, bit se, bit sd, bit we, logic [W-1:0] wd, bit re);
      mrst = m; prst = p; cfg_ld = l; ser_en = se; ser_din = sd;
      wr_en = we; wr_data = wd; rd_en = re;
      @(negedge clk);
   endtask

   task automatic shift_pair(logic [W-1:0] a, logic [W-1:0] f);
      for (int i = 0; i < 2 * W; i++) begin
         cyc(0, 0, 1, 1, (i < W) ? a[i] : f[i - W], 0, '0, 0);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
   end

   initial begin
      logic [W-1:0] la, lf, x, y;
      la = '0; lf = '0;
      cyc(1, 0, 1, 0, 0, 0, '0, 0);
      chk("R1 ae default high", ae_offset, 10'd1023);
      chk("R1 af default high", af_offset, 10'd1023);
      chk("R1 rd cleared", rd_data, '0);

      // R4/R5/R6 parallel sweep over every value
      for (int v = 0; v < (1 << W); v++) begin
         logic [W-1:0] a, f;
         a = W'(v);
         f = a ^ 10'h2AA;
         cyc(0, 0, 1, 0, 0, 1, a, 0);
         chk("R4 ae write", ae_offset, a);
         cyc(0, 0, 1, 0, 0, 1, f, 0);
         chk("R4 af write", af_offset, f);
         chk("R4 ae kept", ae_offset, a);
         cyc(0, 0, 1, 0, 0, 0, '0, 1);
         chk("R5 read ae", rd_data, a);
         cyc(0, 0, 0, 0, 0, 0, '0, 1);
         chk("R6 hold without load", rd_data, a);
         cyc(0, 0, 1, 0, 0, 0, '0, 1);
         chk("R5 read af", rd_data, f);
         la = a; lf = f;
      end

      // R8 serial strobes ignored in parallel mode
      for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 1, 0, '0, 0);
      chk("R8 ser ignored ae", ae_offset, la);
      chk("R8 ser ignored af", af_offset, lf);
      cyc(0, 0, 0, 0, 0, 1, 10'd5, 0);
      chk("R8 wr without load ae", ae_offset, la);
      chk("R8 wr without load af", af_offset, lf);

      // R7 partial reset returns pointer, keeps values
      cyc(0, 0, 1, 0, 0, 1, 10'd100, 0);
      chk("R4 ae 100", ae_offset, 10'd100);
      cyc(0, 1, 1, 0, 0, 1, 10'd77, 1);
      chk("R7 prst keeps ae", ae_offset, 10'd100);
      chk("R7 prst keeps af", af_offset, lf);
      chk("R7 prst no read", rd_data, lf);
      cyc(0, 0, 1, 0, 0, 1, 10'd200, 0);
      chk("R7 pointer home ae", ae_offset, 10'd200);
      chk("R7 pointer home af", af_offset, lf);

      // R9 write wins over readback
      cyc(0, 0, 1, 0, 0, 1, 10'd300, 1);
      chk("R9 write done", af_offset, 10'd300);
      chk("R9 no readback", rd_data, lf);
      cyc(0, 0, 1, 0, 0, 0, '0, 1);
      chk("R5 read after write", rd_data, 10'd200);

      // R9 master over partial, R1 low default, R2 serial mode
      cyc(1, 1, 0, 0, 0, 0, '0, 0);
      chk("R1 ae default low", ae_offset, 10'd127);
      chk("R1 af default low", af_offset, 10'd127);
      chk("R9 mrst wins rd", rd_data, '0);
      cyc(0, 0, 1, 0, 0, 1, 10'd555, 0);
      chk("R8 wr ignored in serial", ae_offset, 10'd127);
      chk("R2 serial mode kept af", af_offset, 10'd127);

      // R3 serial chains over many patterns, R5 readback in serial mode
      for (int k = 0; k < 64; k++) begin
         x = W'((k * 37 + 3) % 1024);
         y = W'((k * 91 + 5) % 1024);
         shift_pair(x, y);
         chk("R3 serial ae", ae_offset, x);
         chk("R3 serial af", af_offset, y);
         cyc(0, 0, 1, 0, 0, 0, '0, 1);
         chk("R5 serial read ae", rd_data, x);
         cyc(0, 0, 1, 0, 0, 0, '0, 1);
         chk("R5 serial read af", rd_data, y);
         la = x; lf = y;
      end

      // R3 partial chain: only low bits of ae move
      cyc(0, 0, 1, 1, 1, 0, '0, 0);
      cyc(0, 0, 1, 1, 0, 0, '0, 0);
      cyc(0, 0, 1, 1, 1, 0, '0, 0);
      chk("R3 partial ae", ae_offset, (la & ~10'd7) | 10'd5);
      chk("R3 partial af", af_offset, lf);
      la = (la & ~10'd7) | 10'd5;
      cyc(0, 1, 1, 1, 0, 0, '0, 0);
      chk("R7 prst keeps serial ae", ae_offset, la);
      x = 10'h15A; y = 10'h2C3;
      shift_pair(x, y);
      chk("R7 serial restart ae", ae_offset, x);
      chk("R7 serial restart af", af_offset, y);
      cyc(0, 0, 1, 1, ~x[0], 0, '0, 0);
      chk("R3 wrap to ae bit0", ae_offset, x ^ 10'd1);
      chk("R3 wrap af kept", af_offset, y);

      // R2 method survives partial reset
      cyc(0, 1, 0, 0, 0, 0, '0, 0);
      cyc(0, 0, 1, 0, 0, 1, 10'd9, 0);
      chk("R2 still serial after prst", ae_offset, x ^ 10'd1);

      // R2 parallel mode ignores serial after master reset high
      cyc(1, 0, 1, 0, 0, 0, '0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 1, 1, 0, 0, '0, 0);
      chk("R2 parallel ignores serial", ae_offset, 10'd1023);
      cyc(0, 0, 1, 0, 0, 1, 10'd42, 0);
      chk("R2 parallel write works", ae_offset, 10'd42);

      summary();
   end
endmodule